// File: doc/BRIEF.md
# Handshake Vector Clock-Domain Synchronizer

This block carries a multi-bit value from one clock domain into a second, unrelated clock domain. No valid strobe is needed from the sender. The source side keeps a one-cycle-old copy of its input and compares it with the live input. Any difference starts a transfer on its own. The value is captured into a holding register and kept frozen while a four-phase request/acknowledge exchange runs. Each control level crosses into the other domain through a two-flop synchronizer. The destination side then copies the frozen value in one step, so the output never shows a mix of old and new bits.

If the input changes again while an exchange is in progress, the change is noted. The newest input value is sent as soon as the exchange completes, so the final value always reaches the destination. Each domain has its own clock and its own active-high synchronous reset. The destination marks every new output value with a one-cycle `dst_update` pulse.

Source states:
- `SRC_IDLE` goes to `SRC_REQ` on launch, which is a change or a pending change. Launch captures the vector and raises the request.
- `SRC_REQ` goes to `SRC_DROP` when the synchronized acknowledge is high. The request is lowered.
- `SRC_DROP` goes back to `SRC_IDLE` when the synchronized acknowledge is low.

Destination states:
- `DST_IDLE` goes to `DST_ACK` when the synchronized request is high. The output is loaded, the strobe pulses and the acknowledge is raised.
- `DST_ACK` goes back to `DST_IDLE` when the synchronized request is low. The acknowledge is lowered.

Top module: `hsync_vector`

## Requirements
- R1: The handshake follows a fixed order: request rises, acknowledge rises, request falls, acknowledge falls. A new request rises only after the acknowledge has fallen.
- R2: A transfer starts only when the input differs from its value one source cycle earlier. An input held constant produces no `dst_update` pulse.
- R3: The request level and the acknowledge level each pass through at least two flip-flops clocked in the receiving domain. The first flop of each chain is a separate register.
- R4: A change seen while an exchange is busy is remembered. After that exchange, the newest input value is sent, so `dst_data` finally equals the last input value.
- R5: The captured vector stays unchanged in its holding register from capture until the source returns to idle. Every value shown on `dst_data` is a value that was present on `src_data`.
- R6: `dst_data` changes only in the cycle where `dst_update` is 1. `dst_update` is 1 for exactly one destination cycle per transfer. There is one pulse per isolated input change.
- R7: Reset clears the request and acknowledge state, the held vector, `dst_data` and `dst_update` to zero.
- R8: When the handshake is idle, an input change appears on `dst_data` within one source cycle plus three destination cycles.
- R9: Values appear on `dst_data` in the same order in which they appeared on `src_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-domain clock |
| src_rst | input | 1 | Source-domain synchronous reset, active high |
| src_data | input | W | Vector to be carried across |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst | input | 1 | Destination-domain synchronous reset, active high |
| dst_data | output | W | Last vector received |
| dst_update | output | 1 | One-cycle pulse when dst_data takes a new value |

## Verification
The two clocks run at 8 ns and 11 ns, so the result of an input change is due one source edge later, after two synchronizer edges, and at a third destination edge. That is at most 1 source plus 3 destination periods. For isolated changes, the bench stamps the time of each change and of each `dst_update` pulse. It requires the gap to be under 45 ns, then checks the value after a settle period that is far longer than the window. For bursts and the full 256-value sweep, exact timing cannot be predicted because changes are merged. A monitor in the destination domain instead checks each pulse against the ordered history of driven values. After each burst it waits 60 source cycles, which is longer than two complete handshakes, and then compares the final value.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_REQ  = 2'd1,
        SRC_DROP = 2'd2
    } src_state_t;

    typedef enum logic {
        DST_IDLE = 1'b0,
        DST_ACK  = 1'b1
    } dst_state_t;

endpackage

// File: rtl/hsync_level_sync.sv
module hsync_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] stage_q;

    // first capture flop, kept as its own register (R3)
    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= 1'b0;
        else     stage_q[0] <= d_async;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= 1'b0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    assign q_sync = stage_q[LAST];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs two stages"); // R3
    end

endmodule

// File: rtl/hsync_src.sv
module hsync_src
    import hsync_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         ack_s,
    output logic         req,
    output logic [W-1:0] hold
);
    src_state_t   state_q, state_d;
    logic [W-1:0] din_q;
    logic         pend_q;
    logic         chg;
    logic         launch;

    assign chg    = (din_q != din);
    assign launch = (state_q == SRC_IDLE) && (chg || pend_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: if (launch) state_d = SRC_REQ;
            SRC_REQ:  if (ack_s)  state_d = SRC_DROP;
            SRC_DROP: if (!ack_s) state_d = SRC_IDLE;
            default:              state_d = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SRC_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            din_q  <= '0;
            hold   <= '0;
            req    <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            din_q <= din;
            req   <= (state_d == SRC_REQ);
            if (launch) begin
                hold   <= din;
                pend_q <= 1'b0;
            end else if (chg) begin
                pend_q <= 1'b1;
            end
        end
    end

    AST_REQ_RISE_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> !$past(ack_s)); // R1
    AST_REQ_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> $past(ack_s)); // R1
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state_q != SRC_IDLE) |=> $stable(hold)); // R5
    AST_CHANGE_PENDS: assert property (@(posedge clk) disable iff (rst)
        (chg && state_q != SRC_IDLE) |=> pend_q); // R4

endmodule

// File: rtl/hsync_dst.sv
module hsync_dst
    import hsync_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_s,
    input  logic [W-1:0] hold_x,
    output logic         ack,
    output logic [W-1:0] dout,
    output logic         upd
);
    dst_state_t state_q, state_d;
    logic       accept;

    assign accept = (state_q == DST_IDLE) && req_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DST_IDLE: if (req_s)  state_d = DST_ACK;
            DST_ACK:  if (!req_s) state_d = DST_IDLE;
            default:              state_d = DST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack  <= 1'b0;
            dout <= '0;
            upd  <= 1'b0;
        end else begin
            ack <= (state_d == DST_ACK);
            upd <= accept;
            if (accept) dout <= hold_x;
        end
    end

    AST_ACK_FALL_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> !$past(req_s)); // R1
    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        upd |=> !upd); // R6
    AST_UPD_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        upd |-> $rose(ack)); // R6
    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !upd |-> $stable(dout)); // R6

endmodule

// File: rtl/hsync_vector.sv
module hsync_vector #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic [W-1:0] src_data,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [W-1:0] dst_data,
    output logic         dst_update
);
    logic         req_src;
    logic         req_dst;
    logic         ack_dst;
    logic         ack_src;
    logic [W-1:0] hold_bus;

    hsync_src #(.W(W)) u_src (
        .clk   (src_clk),
        .rst   (src_rst),
        .din   (src_data),
        .ack_s (ack_src),
        .req   (req_src),
        .hold  (hold_bus)
    );

    hsync_level_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk     (dst_clk),
        .rst     (dst_rst),
        .d_async (req_src),
        .q_sync  (req_dst)
    );

    hsync_level_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (src_clk),
        .rst     (src_rst),
        .d_async (ack_dst),
        .q_sync  (ack_src)
    );

    hsync_dst #(.W(W)) u_dst (
        .clk    (dst_clk),
        .rst    (dst_rst),
        .req_s  (req_dst),
        .hold_x (hold_bus),
        .ack    (ack_dst),
        .dout   (dst_data),
        .upd    (dst_update)
    );

endmodule

// File: tb/hsync_vector_tb.sv
`timescale 1ns/1ps
module hsync_vector_tb;
    localparam int W = 8;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst = 1'b1;
    logic         dst_rst = 1'b1;
    logic [W-1:0] src_data = '0;
    logic [W-1:0] dst_data;
    logic         dst_update;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    logic [W-1:0] hist [0:1023];
    int  nhist    = 1;
    int  last_idx = 0;
    int  upd_cnt  = 0;
    real last_upd_t = 0.0;
    logic upd_prev = 1'b0;

    always #4.0 src_clk = ~src_clk;
    always #5.5 dst_clk = ~dst_clk;

    hsync_vector #(.W(W), .SYNC_STAGES(2)) u_dut (
        .src_clk    (src_clk),
        .src_rst    (src_rst),
        .src_data   (src_data),
        .dst_clk    (dst_clk),
        .dst_rst    (dst_rst),
        .dst_data   (dst_data),
        .dst_update (dst_update)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic drive(input logic [W-1:0] v, input int cycles);
        @(negedge src_clk);
        src_data = v;
        hist[nhist] = v;
        nhist++;
        repeat (cycles - 1) @(negedge src_clk);
    endtask

    // destination-side monitor: R5, R6, R9
    always @(negedge dst_clk) begin
        if (!dst_rst) begin
            if (dst_update) begin
                int found;
                found = -1;
                upd_cnt++;
                last_upd_t = $realtime;
                chk(!upd_prev, "R6 single-cycle pulse", int'(upd_prev), 0);
                for (int i = last_idx; i < nhist; i++) begin
                    if (hist[i] == dst_data) begin
                        found = i;
                        break;
                    end
                end
                chk(found >= 0, "R5/R9 value from input in order", int'(dst_data), int'(hist[nhist-1]));
                if (found >= 0) last_idx = found;
            end
            upd_prev = dst_update;
        end else begin
            upd_prev = 1'b0;
        end
    end

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        logic [W-1:0] v;
        int base;
        real t0;
        hist[0] = '0;
        repeat (5) @(negedge dst_clk);
        @(negedge src_clk);
        src_rst = 1'b0;
        @(negedge dst_clk);
        dst_rst = 1'b0;
        @(negedge dst_clk);
        // R7 reset values
        chk(dst_data == '0, "R7 data after reset", int'(dst_data), 0);
        chk(dst_update == 1'b0, "R7 strobe after reset", int'(dst_update), 0);

        // R2 constant input gives no update
        repeat (200) @(negedge src_clk);
        chk(upd_cnt == 0, "R2 no update on constant input", upd_cnt, 0);

        // isolated single-bit changes: R2, R6, R8
        v = '0;
        for (int b = 0; b < W; b++) begin
            v = v ^ (W'(1) << b);
            base = upd_cnt;
            @(negedge src_clk);
            src_data = v;
            hist[nhist] = v;
            nhist++;
            t0 = $realtime;
            repeat (40) @(negedge src_clk);
            chk(dst_data == v, "R2 isolated change delivered", int'(dst_data), int'(v));
            chk(upd_cnt == base + 1, "R6 one pulse per change", upd_cnt - base, 1);
            chk((last_upd_t - t0) < 45.0, "R8 latency ns", int'(last_upd_t - t0), 45);
        end

        // bursts faster than the handshake: R4
        for (int k = 0; k < 64; k++) begin
            drive(W'((k * 29 + 7) % 256), (k % 5) + 1);
        end
        repeat (60) @(negedge src_clk);
        chk(dst_data == hist[nhist-1], "R4 final burst value", int'(dst_data), int'(hist[nhist-1]));
        chk(last_idx == nhist - 1, "R9 last history entry reached", last_idx, nhist - 1);

        // full sweep, one value per source cycle: R4
        for (int k = 0; k < 256; k++) begin
            drive(W'((k * 97 + 13) % 256), 1);
        end
        repeat (60) @(negedge src_clk);
        chk(dst_data == hist[nhist-1], "R4 final sweep value", int'(dst_data), int'(hist[nhist-1]));

        // steady afterwards: R2
        base = upd_cnt;
        repeat (150) @(negedge src_clk);
        chk(upd_cnt == base, "R2 no update when idle", upd_cnt - base, 0);

        // reset clears outputs: R7
        @(negedge src_clk);
        src_rst = 1'b1;
        dst_rst = 1'b1;
        repeat (4) @(negedge dst_clk);
        chk(dst_data == '0, "R7 data after late reset", int'(dst_data), 0);
        chk(dst_update == 1'b0, "R7 strobe after late reset", int'(dst_update), 0);

        finish_up();
    end

endmodule